// File: doc/BRIEF.md
# Accumulator CPU Instruction Sequencer

A compact accumulator processor core that runs one instruction at a time through a fixed sequence of steps. First it reads the opcode word at the program counter. It then decodes that word and, if the instruction carries an address, reads the next word as that address. It then reads the data operand, executes, and writes a result back to memory when the instruction is a store. After that it returns to the opcode read. The datapath holds a program counter, a memory address register, a memory data register, an opcode register, an operand-address register, an accumulator and three status bits (halted, zero, negative).

The core drives a word memory through an address bus, a read strobe, a write strobe, a word-size indication and separate read and write data buses. The memory returns read data one cycle after the read strobe, and the sequencer spends a dedicated cycle waiting for it. Addresses count bytes, so the program counter advances by the word width in bytes for every word it fetches. A halt instruction freezes the core until the next reset.

Top module: `acc_seq_core`

## Requirements
- R1: While rst_ni is low, pc_o, acc_o, halted_o, zero_o and neg_o are all 0 and no read or write strobe is driven. After release, the first read is the opcode word at address 0.
- R2: Every fetched instruction word, whether opcode or address operand, advances the program counter by 2 (WORD_W/8). Read data is taken from mem_rdata_i in the cycle after mem_rd_o.
- R3: Opcode words are the whole data word with bits above 7 equal to zero. The encodings are NOP 0x0000, CLA 0x0010, JMP 0x0060, JZ 0x0061, JN 0x0062, LDA 0x0091, STA 0x0096, ADD 0x0099, SUB 0x009A, AND 0x009B and HLT 0x00FF. JMP, JZ, JN, LDA, STA, ADD, SUB and AND are each followed by one address word. Any other word executes as a NOP with no operand word.
- R4: LDA loads A with the memory word at the operand address. ADD, SUB and AND combine A with that word (A+M, A−M, A&M), and the result wraps modulo 2^WORD_W. CLA sets A to 0.
- R5: After LDA, ADD, SUB, AND or CLA, zero_o is 1 exactly when A is 0, and neg_o equals the most significant bit of A. No other instruction changes either flag.
- R6: STA writes A to the operand address with one mem_wr_o cycle. It leaves A and the flags unchanged.
- R7: JMP loads the program counter with its address operand. JZ does the same only when zero_o is 1, and JN only when neg_o is 1. Otherwise execution continues after the address word.
- R8: HLT sets halted_o. From then until reset there are no further memory strobes, and the program counter keeps the address following the HLT word.
- R9: mem_rd_o and mem_wr_o are never high together, and mem_word_o is high during every access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mem_addr_o | output | ADDR_W | Byte address of the current access |
| mem_rd_o | output | 1 | Read strobe; data returns next cycle |
| mem_wr_o | output | 1 | Write strobe |
| mem_word_o | output | 1 | Access size is one full word |
| mem_wdata_o | output | WORD_W | Write data |
| mem_rdata_i | input | WORD_W | Read data, valid one cycle after mem_rd_o |
| acc_o | output | WORD_W | Accumulator |
| pc_o | output | ADDR_W | Program counter |
| halted_o | output | 1 | Halted status bit |
| zero_o | output | 1 | Zero status bit |
| neg_o | output | 1 | Negative status bit |

## Verification
The assertions check several rules on every cycle. Each fetched word adds exactly one word step to the program counter. Flag updates track the new accumulator value. Store data equals the accumulator, and a store leaves the accumulator untouched. A halted core stays silent on the bus and in its halt state. Read and write strobes never coincide. Opcode encodings, the unknown-opcode no-op, branch decisions that depend on flags left by earlier instructions, arithmetic wrap-around and the reset clearing of a nonzero accumulator can only be shown by the bench's programs: the store values they produce and the final register state.

// File: rtl/acc_seq_pkg.sv
package acc_seq_pkg;

  typedef enum logic [3:0] {
    ST_F_MAR, ST_F_RD, ST_F_CAP, ST_DEC,
    ST_A_MAR, ST_A_RD, ST_A_CAP, ST_A_LD,
    ST_D_MAR, ST_D_RD, ST_D_CAP, ST_EXEC,
    ST_ST_SET, ST_ST_WR, ST_HALT
  } seq_state_e;

  typedef enum logic [2:0] {
    ALU_PASS, ALU_ADD, ALU_SUB, ALU_AND, ALU_CLR
  } alu_op_e;

  typedef enum logic [1:0] {
    JC_ALWAYS, JC_ZERO, JC_NEG
  } jcond_e;

  localparam logic [7:0] OPC_NOP = 8'h00;
  localparam logic [7:0] OPC_CLA = 8'h10;
  localparam logic [7:0] OPC_JMP = 8'h60;
  localparam logic [7:0] OPC_JZ  = 8'h61;
  localparam logic [7:0] OPC_JN  = 8'h62;
  localparam logic [7:0] OPC_LDA = 8'h91;
  localparam logic [7:0] OPC_STA = 8'h96;
  localparam logic [7:0] OPC_ADD = 8'h99;
  localparam logic [7:0] OPC_SUB = 8'h9A;
  localparam logic [7:0] OPC_AND = 8'h9B;
  localparam logic [7:0] OPC_HLT = 8'hFF;

  typedef struct packed {
    logic    has_addr;
    logic    reads_mem;
    logic    is_store;
    logic    is_jump;
    jcond_e  jcond;
    logic    alu_we;
    alu_op_e alu_op;
    logic    halt;
  } dec_t;

endpackage

// File: rtl/acc_seq_decode.sv
module acc_seq_decode
  import acc_seq_pkg::*;
#(
  parameter int unsigned WORD_W = 16
) (
  input  logic [WORD_W-1:0] instr_i,
  output dec_t              dec_o
);
  logic hi_zero;

  generate
    if (WORD_W > 8) begin : g_hi
      assign hi_zero = (instr_i[WORD_W-1:8] == '0);
    end else begin : g_nohi
      assign hi_zero = 1'b1;
    end
  endgenerate

  always_comb begin
    dec_o = '{has_addr: 1'b0, reads_mem: 1'b0, is_store: 1'b0, is_jump: 1'b0,
              jcond: JC_ALWAYS, alu_we: 1'b0, alu_op: ALU_PASS, halt: 1'b0};
    if (hi_zero) begin
      unique case (instr_i[7:0])
        OPC_CLA: begin dec_o.alu_we = 1'b1; dec_o.alu_op = ALU_CLR; end
        OPC_JMP: begin dec_o.has_addr = 1'b1; dec_o.is_jump = 1'b1; end
        OPC_JZ:  begin dec_o.has_addr = 1'b1; dec_o.is_jump = 1'b1; dec_o.jcond = JC_ZERO; end
        OPC_JN:  begin dec_o.has_addr = 1'b1; dec_o.is_jump = 1'b1; dec_o.jcond = JC_NEG; end
        OPC_LDA: begin dec_o.has_addr = 1'b1; dec_o.reads_mem = 1'b1;
                       dec_o.alu_we = 1'b1; dec_o.alu_op = ALU_PASS; end
        OPC_STA: begin dec_o.has_addr = 1'b1; dec_o.is_store = 1'b1; end
        OPC_ADD: begin dec_o.has_addr = 1'b1; dec_o.reads_mem = 1'b1;
                       dec_o.alu_we = 1'b1; dec_o.alu_op = ALU_ADD; end
        OPC_SUB: begin dec_o.has_addr = 1'b1; dec_o.reads_mem = 1'b1;
                       dec_o.alu_we = 1'b1; dec_o.alu_op = ALU_SUB; end
        OPC_AND: begin dec_o.has_addr = 1'b1; dec_o.reads_mem = 1'b1;
                       dec_o.alu_we = 1'b1; dec_o.alu_op = ALU_AND; end
        OPC_HLT: dec_o.halt = 1'b1;
        default: ;  // NOP and unknown words
      endcase
    end
  end
endmodule

// File: rtl/acc_seq_alu.sv
module acc_seq_alu
  import acc_seq_pkg::*;
#(
  parameter int unsigned WORD_W = 16
) (
  input  logic [WORD_W-1:0] a_i,
  input  logic [WORD_W-1:0] b_i,
  input  alu_op_e           op_i,
  output logic [WORD_W-1:0] res_o
);
  always_comb begin
    unique case (op_i)
      ALU_ADD: res_o = a_i + b_i;
      ALU_SUB: res_o = a_i - b_i;
      ALU_AND: res_o = a_i & b_i;
      ALU_CLR: res_o = '0;
      default: res_o = b_i;
    endcase
  end
endmodule

// File: rtl/acc_seq_ctrl.sv
module acc_seq_ctrl
  import acc_seq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  dec_t       dec_i,
  input  logic       zero_i,
  input  logic       neg_i,
  output seq_state_e state_o,
  output logic       mar_from_pc_o,
  output logic       mar_from_opa_o,
  output logic       mdr_from_mem_o,
  output logic       mdr_from_acc_o,
  output logic       pc_inc_o,
  output logic       pc_jump_o,
  output logic       op_ld_o,
  output logic       opa_ld_o,
  output logic       acc_we_o,
  output logic       halt_set_o,
  output logic       mem_rd_o,
  output logic       mem_wr_o
);
  seq_state_e state_q, state_d;
  logic take_jump;

  assign take_jump = (dec_i.jcond == JC_ALWAYS) ||
                     (dec_i.jcond == JC_ZERO && zero_i) ||
                     (dec_i.jcond == JC_NEG  && neg_i);

  always_comb begin
    state_d        = state_q;
    mar_from_pc_o  = 1'b0;
    mar_from_opa_o = 1'b0;
    mdr_from_mem_o = 1'b0;
    mdr_from_acc_o = 1'b0;
    pc_inc_o       = 1'b0;
    pc_jump_o      = 1'b0;
    op_ld_o        = 1'b0;
    opa_ld_o       = 1'b0;
    acc_we_o       = 1'b0;
    halt_set_o     = 1'b0;
    mem_rd_o       = 1'b0;
    mem_wr_o       = 1'b0;
    unique case (state_q)
      ST_F_MAR: begin mar_from_pc_o = 1'b1; state_d = ST_F_RD; end
      ST_F_RD:  begin mem_rd_o = 1'b1; state_d = ST_F_CAP; end
      ST_F_CAP: begin mdr_from_mem_o = 1'b1; pc_inc_o = 1'b1; state_d = ST_DEC; end
      ST_DEC: begin
        op_ld_o = 1'b1;
        state_d = dec_i.has_addr ? ST_A_MAR : ST_EXEC;
      end
      ST_A_MAR: begin mar_from_pc_o = 1'b1; state_d = ST_A_RD; end
      ST_A_RD:  begin mem_rd_o = 1'b1; state_d = ST_A_CAP; end
      ST_A_CAP: begin mdr_from_mem_o = 1'b1; pc_inc_o = 1'b1; state_d = ST_A_LD; end
      ST_A_LD: begin
        opa_ld_o = 1'b1;
        if (dec_i.is_store)       state_d = ST_ST_SET;
        else if (dec_i.reads_mem) state_d = ST_D_MAR;
        else                      state_d = ST_EXEC;
      end
      ST_D_MAR: begin mar_from_opa_o = 1'b1; state_d = ST_D_RD; end
      ST_D_RD:  begin mem_rd_o = 1'b1; state_d = ST_D_CAP; end
      ST_D_CAP: begin mdr_from_mem_o = 1'b1; state_d = ST_EXEC; end
      ST_EXEC: begin
        acc_we_o   = dec_i.alu_we;
        pc_jump_o  = dec_i.is_jump && take_jump;
        halt_set_o = dec_i.halt;
        state_d    = dec_i.halt ? ST_HALT : ST_F_MAR;
      end
      ST_ST_SET: begin mar_from_opa_o = 1'b1; mdr_from_acc_o = 1'b1; state_d = ST_ST_WR; end
      ST_ST_WR:  begin mem_wr_o = 1'b1; state_d = ST_F_MAR; end
      ST_HALT:   state_d = ST_HALT;
      default:   state_d = ST_F_MAR;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_F_MAR;
    else         state_q <= state_d;
  end

  assign state_o = state_q;

  AST_HALT_TERMINAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HALT) |=> (state_q == ST_HALT)); // R8
  AST_RW_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_rd_o && mem_wr_o)); // R9
endmodule

// File: rtl/acc_seq_core.sv
module acc_seq_core
  import acc_seq_pkg::*;
#(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_rd_o,
  output logic              mem_wr_o,
  output logic              mem_word_o,
  output logic [WORD_W-1:0] mem_wdata_o,
  input  logic [WORD_W-1:0] mem_rdata_i,
  output logic [WORD_W-1:0] acc_o,
  output logic [ADDR_W-1:0] pc_o,
  output logic              halted_o,
  output logic              zero_o,
  output logic              neg_o
);
  localparam int unsigned PC_STEP = WORD_W / 8;
  localparam logic [ADDR_W-1:0] PC_INC = ADDR_W'(PC_STEP);

  logic [ADDR_W-1:0] pc_q, mar_q, opa_q, mdr_addr;
  logic [WORD_W-1:0] mdr_q, op_q, acc_q, alu_res, dec_word;
  logic              halt_q, zero_q, neg_q;

  seq_state_e state;
  dec_t       dec;
  logic mar_from_pc, mar_from_opa, mdr_from_mem, mdr_from_acc;
  logic pc_inc, pc_jump, op_ld, opa_ld, acc_we, halt_set, rd, wr;

  generate
    if (ADDR_W <= WORD_W) begin : g_addr_trunc
      assign mdr_addr = mdr_q[ADDR_W-1:0];
    end else begin : g_addr_ext
      assign mdr_addr = {{(ADDR_W-WORD_W){1'b0}}, mdr_q};
    end
  endgenerate

  // decode the freshly read word during ST_DEC, the held opcode afterwards
  assign dec_word = (state == ST_DEC) ? mdr_q : op_q;

  acc_seq_decode #(.WORD_W(WORD_W)) u_dec (
    .instr_i(dec_word),
    .dec_o  (dec)
  );

  acc_seq_alu #(.WORD_W(WORD_W)) u_alu (
    .a_i  (acc_q),
    .b_i  (mdr_q),
    .op_i (dec.alu_op),
    .res_o(alu_res)
  );

  acc_seq_ctrl u_ctrl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .dec_i         (dec),
    .zero_i        (zero_q),
    .neg_i         (neg_q),
    .state_o       (state),
    .mar_from_pc_o (mar_from_pc),
    .mar_from_opa_o(mar_from_opa),
    .mdr_from_mem_o(mdr_from_mem),
    .mdr_from_acc_o(mdr_from_acc),
    .pc_inc_o      (pc_inc),
    .pc_jump_o     (pc_jump),
    .op_ld_o       (op_ld),
    .opa_ld_o      (opa_ld),
    .acc_we_o      (acc_we),
    .halt_set_o    (halt_set),
    .mem_rd_o      (rd),
    .mem_wr_o      (wr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q   <= '0;
      mar_q  <= '0;
      mdr_q  <= '0;
      op_q   <= '0;
      opa_q  <= '0;
      acc_q  <= '0;
      halt_q <= 1'b0;
      zero_q <= 1'b0;
      neg_q  <= 1'b0;
    end else begin
      if (mar_from_pc)       mar_q <= pc_q;
      else if (mar_from_opa) mar_q <= opa_q;
      if (mdr_from_mem)      mdr_q <= mem_rdata_i;
      else if (mdr_from_acc) mdr_q <= acc_q;
      if (pc_inc)            pc_q  <= pc_q + PC_INC;
      else if (pc_jump)      pc_q  <= opa_q;
      if (op_ld)             op_q  <= mdr_q;
      if (opa_ld)            opa_q <= mdr_addr;
      if (acc_we) begin
        acc_q  <= alu_res;
        zero_q <= (alu_res == '0);
        neg_q  <= alu_res[WORD_W-1];
      end
      if (halt_set)          halt_q <= 1'b1;
    end
  end

  assign mem_addr_o  = mar_q;
  assign mem_rd_o    = rd;
  assign mem_wr_o    = wr;
  assign mem_word_o  = rd | wr;
  assign mem_wdata_o = mdr_q;
  assign acc_o       = acc_q;
  assign pc_o        = pc_q;
  assign halted_o    = halt_q;
  assign zero_o      = zero_q;
  assign neg_o       = neg_q;

  AST_PC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_F_CAP || state == ST_A_CAP) |=> (pc_q == $past(pc_q) + PC_INC)); // R2
  AST_READ_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_D_CAP) |=> (mdr_q == $past(mem_rdata_i))); // R2
  AST_FLAG_TRACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_we |=> (zero_q == (acc_q == '0)) && (neg_q == acc_q[WORD_W-1])); // R5
  AST_STORE_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_o |-> (mem_wdata_o == acc_q)); // R6
  AST_STORE_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_o |=> $stable(acc_q) && $stable(zero_q) && $stable(neg_q)); // R6
  AST_HALT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |-> !mem_rd_o && !mem_wr_o); // R8
  AST_HALT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |=> halted_o && $stable(pc_q)); // R8
  AST_SIZE_ON_ACCESS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_rd_o || mem_wr_o) |-> mem_word_o); // R9
endmodule

// File: tb/sim_acc_seq_core.sv
module sim_acc_seq_core;
  localparam int unsigned WORD_W = 16;
  localparam int unsigned ADDR_W = 16;
  localparam int unsigned MEM_WORDS = 512;

  logic              clk = 1'b0;
  logic              rst_ni;
  logic [ADDR_W-1:0] mem_addr;
  logic              mem_rd, mem_wr, mem_word;
  logic [WORD_W-1:0] mem_wdata;
  logic [WORD_W-1:0] mem_rdata;
  logic [WORD_W-1:0] acc;
  logic [ADDR_W-1:0] pc;
  logic              halted, zero, neg;

  always #2 clk = ~clk;  // 250 MHz

  acc_seq_core #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u0 (
    .clk_i(clk), .rst_ni(rst_ni),
    .mem_addr_o(mem_addr), .mem_rd_o(mem_rd), .mem_wr_o(mem_wr),
    .mem_word_o(mem_word), .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .acc_o(acc), .pc_o(pc), .halted_o(halted), .zero_o(zero), .neg_o(neg)
  );

  // memory model: one write port shared by loader and core
  logic [WORD_W-1:0] mem [MEM_WORDS];
  logic              ld_en = 1'b0;
  logic [8:0]        ld_idx = '0;
  logic [WORD_W-1:0] ld_val = '0;

  always @(posedge clk) begin
    if (ld_en) mem[ld_idx] <= ld_val;
    else if (mem_wr) mem[mem_addr[9:1]] <= mem_wdata;
    if (mem_rd) mem_rdata <= mem[mem_addr[9:1]];
  end

  int checks = 0;
  int fails  = 0;
  int quiet_err = 0;
  bit done = 1'b0;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [WORD_W-1:0] data;
  } store_t;
  store_t exp_q[$];

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic expect_store(logic [ADDR_W-1:0] a, logic [WORD_W-1:0] d);
    exp_q.push_back('{addr: a, data: d});
  endtask

  task automatic put(logic [ADDR_W-1:0] a, logic [WORD_W-1:0] d);
    @(negedge clk);
    ld_en = 1'b1; ld_idx = a[9:1]; ld_val = d;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic clear_mem();
    for (int i = 0; i < MEM_WORDS; i++) put(ADDR_W'(i * 2), '0);
  endtask

  // monitor: scoreboard on stores, bus rules on every access
  always @(negedge clk) begin
    if (rst_ni) begin
      if (mem_rd && mem_wr) begin
        checks++; fails++;
        $display("FAIL R9 rd+wr together act=1 exp=0");
      end
      if ((mem_rd || mem_wr) && !mem_word) begin
        checks++; fails++;
        $display("FAIL R9 size act=0 exp=1");
      end
      if (halted && (mem_rd || mem_wr)) quiet_err++;
      if (mem_wr) begin
        if (exp_q.size() == 0) begin
          checks++; fails++;
          $display("FAIL R6 unexpected store act=%h@%h exp=none", mem_wdata, mem_addr);
        end else begin
          store_t e;
          e = exp_q.pop_front();
          check("R6 store addr", 32'(mem_addr), 32'(e.addr));
          check("R4 store data", 32'(mem_wdata), 32'(e.data));
        end
      end
    end
  end

  task automatic reset_checks();
    #1;
    check("R1 pc at reset", 32'(pc), 32'h0);
    check("R1 acc at reset", 32'(acc), 32'h0);
    check("R1 halted at reset", 32'(halted), 32'h0);
    check("R1 flags at reset", {30'h0, zero, neg}, 32'h0);
    check("R1 no strobe at reset", {30'h0, mem_rd, mem_wr}, 32'h0);
  endtask

  task automatic run_to_halt();
    int n = 0;
    @(negedge clk);
    rst_ni = 1'b1;
    // first access after reset reads address 0 (R1)
    while (!mem_rd && n < 20) begin @(negedge clk); n++; end
    check("R1 first fetch addr", 32'(mem_addr), 32'h0);
    n = 0;
    while (!halted && n < 5000) begin @(negedge clk); n++; end
    check("R8 halted reached", 32'(halted), 32'h1);
    begin
      logic [ADDR_W-1:0] pc_h = pc;
      repeat (40) @(negedge clk);
      check("R8 pc frozen", 32'(pc), 32'(pc_h));
    end
    check("R8 no access while halted", 32'(quiet_err), 32'h0);
    check("R6 all stores seen", 32'(exp_q.size()), 32'h0);
  endtask

  initial begin
    rst_ni = 1'b0;
    reset_checks();
    // ---- program 1 ----
    clear_mem();
    put(16'h0000, 16'h0091); put(16'h0002, 16'h0100);  // LDA
    put(16'h0004, 16'h0099); put(16'h0006, 16'h0102);  // ADD
    put(16'h0008, 16'h0096); put(16'h000A, 16'h0200);  // STA
    put(16'h000C, 16'h009A); put(16'h000E, 16'h0104);  // SUB
    put(16'h0010, 16'h0096); put(16'h0012, 16'h0202);  // STA
    put(16'h0014, 16'h0061); put(16'h0016, 16'h0030);  // JZ
    put(16'h0018, 16'h00FF);
    put(16'h0030, 16'h0091); put(16'h0032, 16'h0106);  // LDA
    put(16'h0034, 16'h0062); put(16'h0036, 16'h0040);  // JN
    put(16'h0038, 16'h00FF);
    put(16'h0040, 16'h009B); put(16'h0042, 16'h0108);  // AND
    put(16'h0044, 16'h0096); put(16'h0046, 16'h0204);  // STA
    put(16'h0048, 16'h0061); put(16'h004A, 16'h0060);  // JZ (not taken)
    put(16'h004C, 16'h0060); put(16'h004E, 16'h0070);  // JMP
    put(16'h0050, 16'h00FF); put(16'h0060, 16'h00FF);
    put(16'h0070, 16'h0099); put(16'h0072, 16'h010A);  // ADD wrap
    put(16'h0074, 16'h0096); put(16'h0076, 16'h0206);  // STA
    put(16'h0078, 16'h0010);                           // CLA
    put(16'h007A, 16'h0096); put(16'h007C, 16'h0208);  // STA
    put(16'h007E, 16'h0091); put(16'h0080, 16'h0106);  // LDA
    put(16'h0082, 16'h0000);                           // NOP
    put(16'h0084, 16'h00FF);                           // HLT
    put(16'h0086, 16'h0096);
    put(16'h0100, 16'h0005); put(16'h0102, 16'h0001);
    put(16'h0104, 16'h0006); put(16'h0106, 16'h8003);
    put(16'h0108, 16'h00FF); put(16'h010A, 16'hFFFD);
    put(16'h0208, 16'hAAAA);
    expect_store(16'h0200, 16'h0006);  // R4 LDA+ADD
    expect_store(16'h0202, 16'h0000);  // R4 SUB to zero
    expect_store(16'h0204, 16'h0003);  // R4 AND, R7 JZ/JN taken
    expect_store(16'h0206, 16'h0000);  // R4 wrap, R7 JZ not taken, JMP
    expect_store(16'h0208, 16'h0000);  // R4 CLA
    run_to_halt();
    check("R2 R8 final pc prog1", 32'(pc), 32'h0086);
    check("R4 final acc prog1", 32'(acc), 32'h8003);
    check("R5 flags prog1 z,n", {30'h0, zero, neg}, 32'h1);
    // ---- program 2 ----
    rst_ni = 1'b0;
    quiet_err = 0;
    reset_checks();
    clear_mem();
    put(16'h0000, 16'h1234);                           // unknown -> NOP (R3)
    put(16'h0002, 16'h0099); put(16'h0004, 16'h0100);
    put(16'h0006, 16'h0099); put(16'h0008, 16'h0102);
    put(16'h000A, 16'h0096); put(16'h000C, 16'h0200);
    put(16'h000E, 16'h0062); put(16'h0010, 16'h0020);  // JN taken
    put(16'h0012, 16'h0096); put(16'h0014, 16'h0202);  // skipped
    put(16'h0020, 16'h00FF);
    put(16'h0100, 16'h7FFF); put(16'h0102, 16'h0001);
    expect_store(16'h0200, 16'h8000);  // R3 unknown opcode no operand
    run_to_halt();
    check("R2 R8 final pc prog2", 32'(pc), 32'h0022);
    check("R4 final acc prog2", 32'(acc), 32'h8000);
    check("R5 flags prog2 z,n", {30'h0, zero, neg}, 32'h1);
    check("R3 R7 mem at skipped store", 32'(mem[9'h101]), 32'h0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule